// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Receiver

This block turns an NRZ serial line into characters. The idle line is high. A frame has a low start bit, then eight or nine data bits with the least significant bit first, then a high stop bit. A shared baud generator supplies a one-cycle tick at sixteen times the bit rate. The receiver counts ticks to find the middle of each bit and takes a majority vote over three samples there.

Finished characters go into a two-entry queue. Each entry holds the data byte, the ninth bit and a framing-error bit. The consumer sees the oldest entry at the outputs and removes it with a read strobe. If a character arrives while the queue is full, it is dropped and a sticky overrun flag sets. Reception stays blocked until the enable is dropped and raised again.

For multidrop buses an address mode is provided. In that mode only nine-bit characters whose ninth bit is 1 are kept, so a node hears address words until software turns the mode off for its own data phase.

Top module: `serial_rx_multidrop`

## Requirements
- R1: With `rx_en` high and the receiver idle, a low line seen on a tick starts a frame. The detection tick counts as tick 0 of the start bit. Every bit is 16 ticks long. Each bit is decided by a majority vote of the samples taken on ticks 7, 8 and 9 of that bit.
- R2: When the stop bit is decided, the character is written into a two-entry queue, oldest first, and `rd_avail` goes to 1. The data bits are received least significant bit first.
- R3: A one-cycle `rd_pop` removes the head entry. `rd_avail` is 0 once the queue is empty. A pop on an empty queue has no effect. While the queue is empty, `rd_data` reads 0.
- R4: If a character is accepted while the queue holds two entries and no pop occurs in that cycle, `ovr_err` goes to 1 and the character is discarded.
- R5: While `ovr_err` is 1, no frame is started (`rx_idle` stays 1). The stored entries can still be read in order.
- R6: `ovr_err` stays set until `rx_en` is low for at least one cycle, or until reset. Lowering `rx_en` also abandons any frame in progress but keeps the queue contents.
- R7: A stop bit decided as 0 stores the character with its framing bit set to 1. The next frame is received normally.
- R8: `rd_ferr` shows the framing bit of the head entry. It reads 0 when the queue is empty.
- R9: With `nine_bit` = 1 a frame carries nine data bits, and the ninth is shown on `rd_ninth` for its entry. With `nine_bit` = 0, `rd_ninth` is 0.
- R10: With `addr_mode` = 1, a character is stored only if `nine_bit` = 1 and its ninth bit is 1. Any other character is dropped and does not cause an overrun.
- R11: `rx_idle` is 1 when no frame is in progress. It is 0 from the detection tick until the stop bit is decided.
- R12: If the start bit is voted high, the frame is abandoned as a glitch: the receiver returns to idle and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_en | input | 1 | Receiver enable; a low level clears overrun |
| nine_bit | input | 1 | 1 selects nine data bits per frame |
| addr_mode | input | 1 | 1 keeps only characters whose ninth bit is 1 |
| rd_pop | input | 1 | Removes the head entry |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rd_data | output | 8 | Head entry data byte |
| rd_ninth | output | 1 | Head entry ninth bit |
| rd_avail | output | 1 | Queue holds at least one entry |
| rd_ferr | output | 1 | Head entry framing error |
| ovr_err | output | 1 | Sticky overrun flag |
| rx_idle | output | 1 | No frame in progress |

## Verification
The hardest state to reach from the ports is the overrun lockout together with the entries that came before it. The bench fills the queue with two distinct characters and sends a third without reading, then sends a fourth while the flag is up. It checks that the receiver stays idle during that fourth frame and that only the first two characters come out. It then toggles `rx_en` and checks that reception resumes. A framing error is produced by driving the stop bit low, and only half of a stop bit is left before the next frame can start. This exercises the receiver's early return to idle.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_t;

    typedef struct packed {
        logic       ferr;
        logic       ninth;
        logic [7:0] data;
    } rx_entry_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/rxm_sync.sv
module rxm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rxm_frame.sv
module rxm_frame
    import rxm_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      tick,
    input  logic      line,
    input  logic      nine,
    output logic      done,
    output rx_entry_t ent,
    output logic      idle
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2;

    rx_state_t     state;
    logic [CW-1:0] cnt;
    logic [1:0]    smp;
    logic [3:0]    idx;
    logic [8:0]    sh;
    logic          nine_l;
    logic          v_now;
    logic          at_vote;
    logic          at_end;

    always_comb begin
        v_now   = vote3({smp, line});
        at_vote = tick && (state != ST_IDLE) && (cnt == CW'(MID + 1));
        at_end  = tick && (state != ST_IDLE) && (cnt == CW'(OVS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            smp    <= '0;
            idx    <= '0;
            sh     <= '0;
            nine_l <= 1'b0;
        end else if (tick) begin
            if (state == ST_IDLE) begin
                if (!line) begin
                    state  <= ST_START;
                    cnt    <= CW'(1);
                    nine_l <= nine;
                    sh     <= '0;
                end
            end else begin
                cnt <= at_end ? '0 : cnt + CW'(1);
                if (cnt == CW'(MID - 1) || cnt == CW'(MID))
                    smp <= {smp[0], line};
                if (at_vote) begin
                    case (state)
                        ST_START: if (v_now) state <= ST_IDLE;
                        ST_DATA:  sh[idx] <= v_now;
                        ST_STOP:  state <= ST_IDLE;
                        default:  ;
                    endcase
                end
                if (at_end) begin
                    if (state == ST_START) begin
                        state <= ST_DATA;
                        idx   <= '0;
                    end else if (state == ST_DATA) begin
                        if (idx == (nine_l ? 4'd8 : 4'd7)) state <= ST_STOP;
                        else                               idx   <= idx + 4'd1;
                    end
                end
            end
        end
    end

    always_comb begin
        done      = at_vote && (state == ST_STOP);
        ent.data  = sh[7:0];
        ent.ninth = nine_l & sh[8];
        ent.ferr  = ~v_now;
        idle      = (state == ST_IDLE);
    end
endmodule

// File: rtl/rxm_fifo.sv
module rxm_fifo
    import rxm_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  rx_entry_t wdata,
    input  logic      pop,
    output rx_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [NW-1:0] num;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            num <= '0;
        end else begin
            if (push) begin
                mem[wp] <= wdata;
                wp      <= nxt(wp);
            end
            if (pop) rp <= nxt(rp);
            if (push && !pop)      num <= num + NW'(1);
            else if (pop && !push) num <= num - NW'(1);
        end
    end

    assign empty = (num == '0);
    assign full  = (num == NW'(DEPTH));
    assign head  = mem[rp];
endmodule

// File: rtl/serial_rx_multidrop.sv
module serial_rx_multidrop
    import rxm_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int DEPTH    = 2,
    parameter int SYNC_STG = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_line,
    input  logic       rx_en,
    input  logic       nine_bit,
    input  logic       addr_mode,
    input  logic       rd_pop,
    input  logic       baud_tick,
    output logic [7:0] rd_data,
    output logic       rd_ninth,
    output logic       rd_avail,
    output logic       rd_ferr,
    output logic       ovr_err,
    output logic       rx_idle
);
    logic      line_s;
    logic      f_done;
    rx_entry_t f_ent;
    rx_entry_t q_head;
    logic      q_empty;
    logic      q_full;
    logic      accept;
    logic      pop_eff;
    logic      push;

    rxm_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rx_line),
        .q   (line_s)
    );

    rxm_frame #(.OVS(OVS)) u_frame (
        .clk  (clk),
        .rst  (rst),
        .en   (rx_en && !ovr_err),
        .tick (baud_tick),
        .line (line_s),
        .nine (nine_bit),
        .done (f_done),
        .ent  (f_ent),
        .idle (rx_idle)
    );

    always_comb begin
        accept  = f_done && (!addr_mode || (nine_bit && f_ent.ninth));
        pop_eff = rd_pop && !q_empty;
        push    = accept && (!q_full || pop_eff);
    end

    rxm_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .wdata (f_ent),
        .pop   (pop_eff),
        .head  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    always_ff @(posedge clk) begin
        if (rst || !rx_en)                    ovr_err <= 1'b0;
        else if (accept && q_full && !pop_eff) ovr_err <= 1'b1;
    end

    always_comb begin
        rd_avail = !q_empty;
        rd_data  = q_empty ? 8'h00 : q_head.data;
        rd_ninth = !q_empty && q_head.ninth;
        rd_ferr  = !q_empty && q_head.ferr;
    end
endmodule

// File: rtl/rxm_checker.sv
module rxm_checker (
    input logic clk,
    input logic rst,
    input logic rx_en,
    input logic rd_pop,
    input logic rd_avail,
    input logic rd_ferr,
    input logic ovr_err,
    input logic rx_idle
);
    assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(ovr_err) && $past(rx_en) && rx_en) |-> ovr_err);

    assert_ovr_lockout_R5: assert property (@(posedge clk) disable iff (rst)
        ovr_err |-> rx_idle);

    assert_ovr_no_new_data_R5: assert property (@(posedge clk) disable iff (rst)
        (ovr_err && $past(ovr_err) && !$past(rd_pop)) |-> $stable(rd_avail));

    assert_ferr_needs_entry_R8: assert property (@(posedge clk) disable iff (rst)
        rd_ferr |-> rd_avail);

    assert_start_needs_en_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_idle) |-> $past(rx_en));

    assert_push_ends_frame_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_avail) |-> $past(!rx_idle));
endmodule

bind serial_rx_multidrop rxm_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_en    (rx_en),
    .rd_pop   (rd_pop),
    .rd_avail (rd_avail),
    .rd_ferr  (rd_ferr),
    .ovr_err  (ovr_err),
    .rx_idle  (rx_idle)
);

// File: tb/sim_serial_rx_multidrop.sv
`timescale 1ns/1ps
module sim_serial_rx_multidrop;
    localparam int BITCLK = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       rx_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       addr_mode = 1'b0;
    logic       rd_pop = 1'b0;
    logic       baud_tick = 1'b0;
    logic [7:0] rd_data;
    logic       rd_ninth, rd_avail, rd_ferr, ovr_err, rx_idle;

    int n_chk = 0;
    int n_err = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) baud_tick <= rst ? 1'b0 : ~baud_tick;

    serial_rx_multidrop u0 (
        .clk(clk), .rst(rst), .rx_line(rx_line), .rx_en(rx_en),
        .nine_bit(nine_bit), .addr_mode(addr_mode), .rd_pop(rd_pop),
        .baud_tick(baud_tick), .rd_data(rd_data), .rd_ninth(rd_ninth),
        .rd_avail(rd_avail), .rd_ferr(rd_ferr), .ovr_err(ovr_err),
        .rx_idle(rx_idle)
    );

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int clks);
        rx_line = v;
        repeat (clks) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic b9, input int nbits, input logic stopv);
        hold(1'b0, BITCLK);
        for (int i = 0; i < 8; i++) hold(d[i], BITCLK);
        if (nbits == 9) hold(b9, BITCLK);
        hold(stopv, BITCLK);
        hold(1'b1, BITCLK);
    endtask

    task automatic pop1;
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R3 reset avail", {8'h0, rd_avail}, 9'h0);
        chk("R11 reset idle", {8'h0, rx_idle}, 9'h1);
        chk("R6 reset ovr", {8'h0, ovr_err}, 9'h0);
        chk("R8 reset ferr", {8'h0, rd_ferr}, 9'h0);
    endtask

    task automatic t_basic;
        send(8'hA5, 1'b0, 8, 1'b1);
        chk("R2 avail", {8'h0, rd_avail}, 9'h1);
        chk("R2 data", {1'b0, rd_data}, 9'h0A5);
        chk("R9 ninth in 8-bit", {8'h0, rd_ninth}, 9'h0);
        pop1;
        chk("R3 empty after pop", {8'h0, rd_avail}, 9'h0);
        chk("R3 data zero when empty", {1'b0, rd_data}, 9'h0);
        pop1;
        chk("R3 pop on empty", {8'h0, rd_avail}, 9'h0);
    endtask

    task automatic t_order_idle;
        fork
            send(8'h3E, 1'b0, 8, 1'b1);
            begin
                repeat (BITCLK * 4) @(negedge clk);
                chk("R11 busy mid frame", {8'h0, rx_idle}, 9'h0);
            end
        join
        send(8'hC1, 1'b0, 8, 1'b1);
        chk("R2 first out", {1'b0, rd_data}, 9'h03E);
        pop1;
        chk("R2 second out", {1'b0, rd_data}, 9'h0C1);
        pop1;
        chk("R3 drained", {8'h0, rd_avail}, 9'h0);
    endtask

    task automatic t_overrun;
        send(8'h11, 1'b0, 8, 1'b1);
        send(8'h22, 1'b0, 8, 1'b1);
        chk("R4 no ovr at two", {8'h0, ovr_err}, 9'h0);
        send(8'h33, 1'b0, 8, 1'b1);
        chk("R4 ovr set", {8'h0, ovr_err}, 9'h1);
        fork
            send(8'h44, 1'b0, 8, 1'b1);
            begin
                repeat (BITCLK * 3) @(negedge clk);
                chk("R5 locked idle", {8'h0, rx_idle}, 9'h1);
            end
        join
        chk("R5 head kept", {1'b0, rd_data}, 9'h011);
        pop1;
        chk("R5 second kept", {1'b0, rd_data}, 9'h022);
        pop1;
        chk("R4 third lost", {8'h0, rd_avail}, 9'h0);
        chk("R6 ovr holds", {8'h0, ovr_err}, 9'h1);
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
        chk("R6 ovr cleared", {8'h0, ovr_err}, 9'h0);
        send(8'h55, 1'b0, 8, 1'b1);
        chk("R6 receive resumes", {rd_avail, rd_data}, 9'h155);
        pop1;
    endtask

    task automatic t_framing;
        send(8'h96, 1'b0, 8, 1'b0);
        send(8'h69, 1'b0, 8, 1'b1);
        chk("R7 bad entry data", {1'b0, rd_data}, 9'h096);
        chk("R8 head ferr", {8'h0, rd_ferr}, 9'h1);
        pop1;
        chk("R7 next received", {rd_avail, rd_data}, 9'h169);
        chk("R8 ferr follows head", {8'h0, rd_ferr}, 9'h0);
        pop1;
    endtask

    task automatic t_nine;
        nine_bit = 1'b1;
        send(8'h3C, 1'b1, 9, 1'b1);
        send(8'hF0, 1'b0, 9, 1'b1);
        chk("R9 ninth one", {rd_ninth, rd_data}, 9'h13C);
        pop1;
        chk("R9 ninth zero", {rd_ninth, rd_data}, 9'h0F0);
        pop1;
    endtask

    task automatic t_addr;
        nine_bit = 1'b1;
        addr_mode = 1'b1;
        send(8'h12, 1'b0, 9, 1'b1);
        chk("R10 data word dropped", {8'h0, rd_avail}, 9'h0);
        send(8'h7A, 1'b1, 9, 1'b1);
        chk("R10 address kept", {rd_ninth, rd_data}, 9'h17A);
        pop1;
        nine_bit = 1'b0;
        send(8'h5B, 1'b0, 8, 1'b1);
        send(8'h5C, 1'b0, 8, 1'b1);
        send(8'h5D, 1'b0, 8, 1'b1);
        chk("R10 8-bit dropped", {8'h0, rd_avail}, 9'h0);
        chk("R10 no ovr from drops", {8'h0, ovr_err}, 9'h0);
        addr_mode = 1'b0;
    endtask

    task automatic t_glitch;
        hold(1'b0, 4);
        hold(1'b1, BITCLK * 2);
        chk("R12 back to idle", {8'h0, rx_idle}, 9'h1);
        chk("R12 nothing stored", {8'h0, rd_avail}, 9'h0);
        send(8'h81, 1'b0, 8, 1'b1);
        chk("R1 after glitch", {rd_avail, rd_data}, 9'h181);
        pop1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        t_reset;
        t_basic;
        t_order_idle;
        t_overrun;
        t_framing;
        t_nine;
        t_addr;
        t_glitch;
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule